// File: doc/BRIEF.md
# Asynchronous Memory Copy Engine

The engine takes memory-to-memory copy jobs without stalling the requester. A job names a source word address, a destination word address, a word count and an owner number. In the cycle the engine accepts a job, it hands back a completion token. Accepted jobs wait in a four-slot table. They are carried out one at a time, oldest first, over a single-word memory master port. Each word costs one read beat followed by one write beat.

Software can look up any token through a combinational status port and learn whether that job is invalid, still pending or finished. A kill input purges every live job of one owner and leaves all other jobs alone. A pause input freezes the engine between beats. The current source pointer, destination pointer and remaining count are held in live registers, so the copy picks up at the next word when pause drops.

Top module: `async_copy_engine`

## Requirements
- R1: A job is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. In that same cycle `cmd_token` carries {generation[3:2], slot index[1:0]}, where the generation is one more than that slot's previous generation. The slot chosen is the lowest-numbered slot that is neither pending nor active.
- R2: `qry_status` reads 2'b00 for invalid, 2'b01 for pending and 2'b10 for done. A job with a nonzero count reads pending from acceptance until the edge of its last write beat, and done after that edge.
- R3: At most four jobs are pending or active at once. While four are live, `cmd_ready` is low and a held request waits. It is accepted once a slot frees, and it is not lost.
- R4: A job with count N copies the words at source+k to destination+k, for k = 0..N-1. A beat completes on an edge where `mem_req` and `mem_gnt` are both high. Read data is taken in the same cycle as the read beat, and the matching write follows, carrying that data. No other address is written.
- R5: Only one job is active at a time. Pending jobs start in the order they were accepted.
- R6: While `pause` is high, `mem_req` stays low and no beat happens. When `pause` drops, the copy continues at the next word, with no word skipped or repeated.
- R7: A cycle with `kill_valid` high turns every pending or active job whose owner equals `kill_owner` invalid. If the active job is among them, it issues no further beat after that edge. Jobs of other owners are untouched, and a job accepted in the same cycle as the kill survives.
- R8: A done slot can be handed out again. Once it is reused, the old token reads invalid.
- R9: A job with count zero reads done in the cycle after its acceptance and causes no memory request.
- R10: After reset every token reads invalid, `cmd_ready` is high and `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Copy job offered |
| cmd_ready | output | 1 | A slot is available |
| cmd_src | input | AW | Source word address |
| cmd_dst | input | AW | Destination word address |
| cmd_len | input | LW | Word count |
| cmd_owner | input | OW | Owner number |
| cmd_token | output | IW+GW | Token of the job accepted this cycle |
| qry_token | input | IW+GW | Token to look up |
| qry_status | output | 2 | Status of the looked-up token |
| kill_valid | input | 1 | Purge the jobs of one owner |
| kill_owner | input | OW | Owner to purge |
| pause | input | 1 | Hold the engine between beats |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Beat address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the cycle of the read beat |
| mem_gnt | input | 1 | Memory accepts the beat this cycle |

## Verification
The assertions assume that `mem_rdata` is valid in the same cycle as a granted read. They also assume `mem_gnt` means something only while `mem_req` is high. The stimulus keeps to this by modelling the memory as a bench array read combinationally at `mem_addr`, with the grant either always high or skipping every third cycle. The full-table and freeze properties further assume that nothing outside the engine changes its table except through `kill_valid`. All inputs change only on the falling edge, so every job, kill and pause lands on a known edge.

// File: rtl/async_copy_engine.sv
module async_copy_engine #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 8,
  parameter int OW = 2,
  parameter int DEPTH = 4,
  parameter int GW = 2,
  localparam int IW = $clog2(DEPTH),
  localparam int TW = IW + GW
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_src,
  input  logic [AW-1:0] cmd_dst,
  input  logic [LW-1:0] cmd_len,
  input  logic [OW-1:0] cmd_owner,
  output logic [TW-1:0] cmd_token,
  input  logic [TW-1:0] qry_token,
  output logic [1:0]    qry_status,
  input  logic          kill_valid,
  input  logic [OW-1:0] kill_owner,
  input  logic          pause,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_gnt
);
  typedef enum logic [1:0] {S_FREE, S_PEND, S_ACT, S_DONE} slot_t;
  typedef enum logic [1:0] {P_IDLE, P_RD, P_WR} phase_t;

  slot_t             st     [DEPTH];
  logic [GW-1:0]     gen    [DEPTH];
  logic [AW-1:0]     e_src  [DEPTH];
  logic [AW-1:0]     e_dst  [DEPTH];
  logic [LW-1:0]     e_len  [DEPTH];
  logic [OW-1:0]     e_own  [DEPTH];
  logic [DEPTH-1:0]  older  [DEPTH];

  phase_t        phase;
  logic [IW-1:0] act;
  logic [AW-1:0] cur_src, cur_dst;
  logic [LW-1:0] rem;
  logic [DW-1:0] hold;

  logic          free_found, pend_found;
  logic [IW-1:0] free_idx, pend_idx;
  logic [GW-1:0] next_gen;
  logic [IW-1:0] q_idx;
  logic [GW-1:0] q_gen;
  logic          busy, beat, start, cmd_acc, kill_act;
  logic [DEPTH-1:0] act_vec;
  logic [OW-1:0] act_own;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (st[i] != S_PEND && st[i] != S_ACT) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    pend_found = 1'b0;
    pend_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (st[j] == S_PEND && older[j][i]) blk = 1'b1;
      if (st[i] == S_PEND && !blk) begin
        pend_found = 1'b1;
        pend_idx   = IW'(i);
      end
    end
    for (int i = 0; i < DEPTH; i++) act_vec[i] = (st[i] == S_ACT);
  end

  assign next_gen   = gen[free_idx] + 1'b1;
  assign cmd_ready  = free_found;
  assign cmd_token  = {next_gen, free_idx};
  assign cmd_acc    = cmd_valid && free_found;
  assign busy       = (phase != P_IDLE);
  assign act_own    = e_own[act];
  assign mem_req    = busy && !pause;
  assign mem_we     = (phase == P_WR);
  assign mem_addr   = mem_we ? cur_dst : cur_src;
  assign mem_wdata  = hold;
  assign beat       = mem_req && mem_gnt;
  assign start      = !busy && pend_found && !pause && !kill_valid;
  assign kill_act   = kill_valid && busy && (act_own == kill_owner);

  assign q_idx      = qry_token[IW-1:0];
  assign q_gen      = qry_token[TW-1:IW];
  assign qry_status = (st[q_idx] == S_FREE || gen[q_idx] != q_gen) ? 2'b00 :
                      (st[q_idx] == S_DONE) ? 2'b10 : 2'b01;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st[i]    <= S_FREE;
        gen[i]   <= '0;
        e_src[i] <= '0;
        e_dst[i] <= '0;
        e_len[i] <= '0;
        e_own[i] <= '0;
        older[i] <= '0;
      end
      phase   <= P_IDLE;
      act     <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      rem     <= '0;
      hold    <= '0;
    end else begin
      if (start) begin
        st[pend_idx] <= S_ACT;
        act     <= pend_idx;
        cur_src <= e_src[pend_idx];
        cur_dst <= e_dst[pend_idx];
        rem     <= e_len[pend_idx];
        phase   <= P_RD;
      end
      if (beat && phase == P_RD) begin
        hold  <= mem_rdata;
        phase <= P_WR;
      end
      if (beat && phase == P_WR) begin
        cur_src <= cur_src + AW'(1);
        cur_dst <= cur_dst + AW'(1);
        rem     <= rem - LW'(1);
        if (rem == LW'(1)) begin
          st[act] <= S_DONE;
          phase   <= P_IDLE;
        end else begin
          phase   <= P_RD;
        end
      end
      if (kill_valid)
        for (int i = 0; i < DEPTH; i++)
          if ((st[i] == S_PEND || st[i] == S_ACT) && e_own[i] == kill_owner)
            st[i] <= S_FREE;
      if (kill_act) phase <= P_IDLE;
      if (cmd_acc) begin
        st[free_idx]    <= (cmd_len == '0) ? S_DONE : S_PEND;
        gen[free_idx]   <= next_gen;
        e_src[free_idx] <= cmd_src;
        e_dst[free_idx] <= cmd_dst;
        e_len[free_idx] <= cmd_len;
        e_own[free_idx] <= cmd_owner;
        older[free_idx] <= '0;
        for (int j = 0; j < DEPTH; j++)
          if (j != int'(free_idx)) older[j][free_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ace_chk.sv
module ace_chk #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int OW = 2,
  parameter int DEPTH = 4
)(
  input logic             clk,
  input logic             rst_n,
  input logic             pause,
  input logic             kill_valid,
  input logic [OW-1:0]    kill_owner,
  input logic             cmd_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_gnt,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_rdata,
  input logic [DW-1:0]    mem_wdata,
  input logic             busy,
  input logic [DEPTH-1:0] act_vec,
  input logic [OW-1:0]    act_own
);
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy == ($countones(act_vec) == 1)); // R5
  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !kill_valid) |=> ($stable(mem_addr) && $stable(mem_we))); // R6
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_gnt && !kill_valid) |=> (mem_we && mem_wdata == $past(mem_rdata))); // R4
  AST_KILL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_valid && busy && act_own == kill_owner) |=> !mem_req); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !kill_valid && !(mem_req && mem_gnt && mem_we)) |=> !cmd_ready); // R3
endmodule

bind async_copy_engine ace_chk #(.AW(AW), .DW(DW), .OW(OW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pause(pause), .kill_valid(kill_valid), .kill_owner(kill_owner),
  .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
  .busy(busy), .act_vec(act_vec), .act_own(act_own)
);

// File: tb/sim_async_copy_engine.sv
module sim_async_copy_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] ST_INV = 2'b00, ST_PEND = 2'b01, ST_DONE = 2'b10;
  localparam logic [15:0] DEAD = 16'hDEAD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready;
  logic [7:0] cmd_src = 0, cmd_dst = 0, cmd_len = 0;
  logic [1:0] cmd_owner = 0;
  logic [3:0] cmd_token, qry_token = 0;
  logic [1:0] qry_status;
  logic kill_valid = 0, pause = 0;
  logic [1:0] kill_owner = 0;
  logic mem_req, mem_we, mem_gnt;
  logic [7:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] mem [256];
  logic bw_en = 0;
  logic [7:0] bw_addr = 0;
  logic [15:0] bw_data = 0;
  logic stall_mode = 0;
  int cyc = 0, wcount = 0, req_cnt = 0, ord_n = 0;
  logic [3:0] last_reg = 4'hF;
  logic [3:0] ord [64];
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  assign mem_gnt = !stall_mode || (cyc % 3 != 0);

  async_copy_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len), .cmd_owner(cmd_owner),
    .cmd_token(cmd_token), .qry_token(qry_token), .qry_status(qry_status),
    .kill_valid(kill_valid), .kill_owner(kill_owner), .pause(pause),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bw_en) mem[bw_addr] <= bw_data;
    if (mem_req) req_cnt <= req_cnt + 1;
    if (mem_req && mem_gnt && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wcount <= wcount + 1;
      if (mem_addr[7:4] != last_reg) begin
        ord[ord_n % 64] <= mem_addr[7:4];
        ord_n <= ord_n + 1;
        last_reg <= mem_addr[7:4];
      end
    end
  end

  function automatic logic [15:0] pat(int a, int s);
    return 16'((a * 37 + s * 101 + 5) & 16'hFFFF);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act_v, input int exp_v);
    total++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    bw_en = 1; bw_addr = 8'(a); bw_data = d;
    tick();
    bw_en = 0;
  endtask

  task automatic fill_pat(input int base, input int seed);
    for (int k = 0; k < 16; k++) poke(base + k, pat(base + k, seed));
  endtask

  task automatic fill_dead(input int base);
    for (int k = 0; k < 16; k++) poke(base + k, DEAD);
  endtask

  task automatic issue(input int s, input int d, input int l, input int o,
                       output logic [3:0] tok, output logic ok);
    cmd_valid = 1; cmd_src = 8'(s); cmd_dst = 8'(d); cmd_len = 8'(l); cmd_owner = 2'(o);
    #1;
    ok = cmd_ready;
    tok = cmd_token;
    tick();
    cmd_valid = 0;
  endtask

  task automatic query(input logic [3:0] t, output logic [1:0] s);
    qry_token = t;
    #1;
    s = qry_status;
  endtask

  task automatic wait_done(input logic [3:0] t);
    logic [1:0] s;
    for (int n = 0; n < 3000; n++) begin
      query(t, s);
      if (s != ST_PEND) break;
      tick();
    end
  endtask

  task automatic wait_writes(input int target);
    for (int n = 0; n < 3000; n++) begin
      if (wcount >= target) break;
      tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [3:0] tok, prev, t5;
    logic [3:0] tq [4];
    logic ok, have_prev;
    logic [1:0] s;
    int rc, w0, base, wc;

    repeat (3) tick();
    rst_n = 1;
    tick();
    // R10: reset state
    check("R10 ready", int'(cmd_ready), 1);
    check("R10 req", int'(mem_req), 0);
    for (int t = 0; t < 16; t++) begin
      query(4'(t), s);
      check("R10 token invalid", int'(s), int'(ST_INV));
    end
    tick();

    // sweep of length and grant pattern
    have_prev = 0;
    prev = '0;
    for (int mode = 0; mode < 2; mode++) begin
      stall_mode = logic'(mode);
      for (int len = 0; len < 8; len++) begin
        fill_pat(8'h00, mode * 8 + len);
        fill_dead(8'h20);
        rc = req_cnt;
        issue(2, 8'h21, len, 0, tok, ok);
        check("R1 accepted", int'(ok), 1);
        check("R1 lowest slot", int'(tok[1:0]), 0);
        if (have_prev) begin
          check("R1 generation step", int'(tok[3:2]), int'(2'(prev[3:2] + 2'd1)));
          query(prev, s);
          check("R8 stale token", int'(s), int'(ST_INV));
        end
        if (len == 0) begin
          query(tok, s);
          check("R9 zero length done", int'(s), int'(ST_DONE));
          check("R9 no memory traffic", req_cnt, rc);
        end else begin
          query(tok, s);
          check("R2 pending", int'(s), int'(ST_PEND));
          wait_done(tok);
          query(tok, s);
          check("R2 done", int'(s), int'(ST_DONE));
          for (int k = 0; k < len; k++)
            check("R4 word copied", int'(mem[8'h21 + k]), int'(pat(2 + k, mode * 8 + len)));
          check("R4 guard after", int'(mem[8'h21 + len]), int'(DEAD));
        end
        check("R4 guard before", int'(mem[8'h20]), int'(DEAD));
        prev = tok;
        have_prev = 1;
        tick();
      end
    end

    // R3 and R5: fill the table while paused, hold a fifth request
    stall_mode = 0;
    fill_pat(8'h00, 40);
    pause = 1;
    for (int k = 0; k < 4; k++) begin
      issue(k, 8'h80 + 16 * k, 3, 0, tq[k], ok);
      check("R3 accepted below cap", int'(ok), 1);
      check("R1 slot order", int'(tq[k][1:0]), k);
    end
    for (int k = 0; k < 4; k++) begin
      query(tq[k], s);
      check("R2 pending while paused", int'(s), int'(ST_PEND));
    end
    cmd_valid = 1; cmd_src = 8'h04; cmd_dst = 8'hC0; cmd_len = 8'd3; cmd_owner = 2'd3;
    #1;
    check("R3 refused when full", int'(cmd_ready), 0);
    tick();
    #1;
    check("R3 still refused", int'(cmd_ready), 0);
    base = ord_n;
    pause = 0;
    ok = 0;
    t5 = '0;
    for (int n = 0; n < 500; n++) begin
      tick();
      #1;
      if (cmd_ready) begin ok = 1; t5 = cmd_token; break; end
    end
    tick();
    cmd_valid = 0;
    check("R3 held request accepted", int'(ok), 1);
    wait_done(t5);
    query(t5, s);
    check("R3 held request done", int'(s), int'(ST_DONE));
    for (int k = 0; k < 3; k++)
      check("R3 held request data", int'(mem[8'hC0 + k]), int'(pat(4 + k, 40)));
    for (int k = 0; k < 5; k++)
      check("R5 start order", int'(ord[(base + k) % 64]), 8 + k);
    tick();

    // R6: pause partway and resume
    stall_mode = 1;
    fill_pat(8'h00, 50);
    fill_dead(8'h60);
    w0 = wcount;
    issue(1, 8'h60, 8, 1, tok, ok);
    wait_writes(w0 + 3);
    pause = 1;
    wc = wcount;
    rc = req_cnt;
    repeat (20) tick();
    check("R6 no writes while paused", wcount, wc);
    check("R6 no requests while paused", req_cnt, rc);
    query(tok, s);
    check("R6 pending while paused", int'(s), int'(ST_PEND));
    pause = 0;
    wait_done(tok);
    query(tok, s);
    check("R6 done after resume", int'(s), int'(ST_DONE));
    check("R6 total writes", wcount - w0, 8);
    for (int k = 0; k < 8; k++)
      check("R6 word after resume", int'(mem[8'h60 + k]), int'(pat(1 + k, 50)));
    tick();

    // R7: kill one owner
    fill_pat(8'h00, 60);
    fill_dead(8'hA0);
    fill_dead(8'hB0);
    fill_dead(8'hC0);
    pause = 1;
    issue(0, 8'hA0, 10, 1, tq[0], ok);
    issue(3, 8'hB0, 4, 2, tq[1], ok);
    issue(5, 8'hC0, 4, 1, tq[2], ok);
    w0 = wcount;
    pause = 0;
    wait_writes(w0 + 2);
    kill_valid = 1; kill_owner = 2'd1;
    tick();
    kill_valid = 0;
    query(tq[0], s);
    check("R7 active victim invalid", int'(s), int'(ST_INV));
    query(tq[2], s);
    check("R7 pending victim invalid", int'(s), int'(ST_INV));
    query(tq[1], s);
    check("R7 other owner kept", int'(s), int'(ST_PEND));
    wait_done(tq[1]);
    query(tq[1], s);
    check("R7 other owner done", int'(s), int'(ST_DONE));
    for (int k = 0; k < 4; k++)
      check("R7 other owner data", int'(mem[8'hB0 + k]), int'(pat(3 + k, 60)));
    for (int k = 0; k < 4; k++)
      check("R7 killed job untouched", int'(mem[8'hC0 + k]), int'(DEAD));
    for (int k = 4; k < 10; k++)
      check("R7 active job stopped", int'(mem[8'hA0 + k]), int'(DEAD));
    check("R7 writes after kill", wcount - w0, 4 + 2 + ((wcount - w0 - 4 > 2) ? 1 : 0));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule